// File: doc/BRIEF.md
# Merged divide-remainder unit

This block is the integer divider of an execution pipeline. One operation yields the quotient and the remainder together. It serves the eight merged divide opcodes: unsigned and signed division at 8, 16, 32 and 64 bits. The instruction decoder drives a width code and a signed flag, both taken from the opcode, and places the dividend (third operand) and the divisor (fourth operand) on the inputs. It then pulses `start`. The block raises `busy` while it works and pulses `done` when finished. The quotient is meant for the first destination register and the remainder for the second.

The divider works on operand magnitudes with a restoring radix-2 recurrence. Each clock produces one quotient bit, and an operation runs for as many clocks as the selected width has bits. Signs are applied afterwards, and results narrower than the datapath are extended to full width. A zero divisor never traps. The result is fixed: a quotient of all ones and the dividend passed through as the remainder. That result is ready one cycle after the request.

Top module: `divrem_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and `quotient` and `remainder` are both zero.
- R2: `op_size` selects the width N: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64, which matches the two low opcode bits. `op_signed`=0 selects unsigned division. The quotient and the remainder of the low N bits of the two operands are returned zero-extended to 64 bits.
- R3: With `op_signed`=1 the low N bits are two's-complement values. The quotient truncates toward zero and the remainder carries the sign of the dividend. Both results are sign-extended from bit N-1.
- R4: A signed division of the most negative N-bit value by -1 wraps. It returns that same most negative value, sign-extended, as the quotient and 0 as the remainder.
- R5: When the low N bits of the divisor are all zero, `done` is high in the cycle after the accepting edge and `busy` stays low. `quotient` is all ones across 64 bits. `remainder` is the low N bits of the dividend, extended according to `op_signed`.
- R6: For a nonzero divisor, `busy` is high for exactly N cycles starting at the edge that accepts `start`. `done` is high for exactly one cycle, starting at the edge where `busy` falls, and the results are valid from that cycle. `busy` and `done` are never high together.
- R7: A `start` pulse while `busy` is high is ignored. The operation in flight keeps its duration and its results.
- R8: While `busy` is low and no `start` arrives, `quotient` and `remainder` keep their values.
- R9: Operand bits above bit N-1 have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| op_size | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| op_signed | input | 1 | 1 selects signed division |
| dividend | input | 64 | Dividend (third operand) |
| divisor | input | 64 | Divisor (fourth operand) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Quotient, for the first destination |
| remainder | output | 64 | Remainder, for the second destination |

## Verification
The bench builds the unit with its default 64-bit datapath. At that size all four width codes exist, so the one stimulus table covers 8-bit cycle counts as well as full 64-step runs. It also reaches the wrap of the most negative value divided by -1 at both 16 and 64 bits. Upper operand bits are filled with garbage so that narrowing and extension are exposed, and zero divisors that are zero only in the low bits test the width-aware zero detection.

// File: rtl/divrem_pkg.sv
`timescale 1ns/1ps
package divrem_pkg;

   // Width code, equal to the two low bits of the opcode
   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } dr_size_e;

   localparam int NUM_SIZES = 4;

   // Top-level control state
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dr_state_e;

endpackage

// File: rtl/divrem_prep.sv
`timescale 1ns/1ps
// Narrows operands to the selected width and forms magnitudes and sign flags
module divrem_prep
   import divrem_pkg::*;
#(
   parameter  int DATA_W = 64,
   localparam int CNT_W  = $clog2(DATA_W + 1)
) (
   input  dr_size_e          size,
   input  logic              is_signed,
   input  logic [DATA_W-1:0] dividend,
   input  logic [DATA_W-1:0] divisor,
   output logic [DATA_W-1:0] dvd_aligned,
   output logic [DATA_W-1:0] dsr_mag,
   output logic [DATA_W-1:0] dvd_ext,
   output logic              neg_dvd,
   output logic              neg_dsr,
   output logic              dsr_zero,
   output logic [CNT_W-1:0]  nbits
);

   logic [DATA_W-1:0] c_al  [NUM_SIZES];
   logic [DATA_W-1:0] c_bm  [NUM_SIZES];
   logic [DATA_W-1:0] c_ext [NUM_SIZES];
   logic              c_na  [NUM_SIZES];
   logic              c_nb  [NUM_SIZES];
   logic              c_bz  [NUM_SIZES];
   logic [CNT_W-1:0]  c_nbt [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_w
      localparam int W = DATA_W >> (NUM_SIZES - 1 - g);
      localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - W);

      logic [DATA_W-1:0] a_z, b_z, a_s, b_s;
      logic              a_neg, b_neg;

      assign a_z   = dividend & MASK;
      assign b_z   = divisor & MASK;
      assign a_neg = is_signed & dividend[W-1];
      assign b_neg = is_signed & divisor[W-1];
      assign a_s   = a_neg ? (a_z | ~MASK) : a_z;
      assign b_s   = b_neg ? (b_z | ~MASK) : b_z;

      // magnitude placed at the top so the recurrence always starts at the MSB
      assign c_al[g]  = (a_neg ? ((-a_s) & MASK) : a_z) << (DATA_W - W);
      assign c_bm[g]  = b_neg ? ((-b_s) & MASK) : b_z;
      assign c_ext[g] = a_s;
      assign c_na[g]  = a_neg;
      assign c_nb[g]  = b_neg;
      assign c_bz[g]  = (b_z == '0);
      assign c_nbt[g] = CNT_W'(W);
   end

   always_comb begin
      dvd_aligned = c_al[size];
      dsr_mag     = c_bm[size];
      dvd_ext     = c_ext[size];
      neg_dvd     = c_na[size];
      neg_dsr     = c_nb[size];
      dsr_zero    = c_bz[size];
      nbits       = c_nbt[size];
   end

endmodule

// File: rtl/divrem_core.sv
`timescale 1ns/1ps
// Restoring radix-2 recurrence on magnitudes, one quotient bit per step
module divrem_core #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [DATA_W-1:0] dvd_in,
   input  logic [DATA_W-1:0] dsr_in,
   output logic [DATA_W-1:0] quo_mag,
   output logic [DATA_W-1:0] rem_mag
);

   logic [DATA_W-1:0] shreg_q;   // dividend bits out at the top, quotient bits in at the bottom
   logic [DATA_W-1:0] part_q;    // partial remainder
   logic [DATA_W-1:0] dsr_q;
   logic [DATA_W:0]   shifted;
   logic [DATA_W:0]   trial;
   logic              fits;

   always_comb begin
      shifted = {part_q, shreg_q[DATA_W-1]};
      trial   = shifted - {1'b0, dsr_q};
      fits    = ~trial[DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         part_q  <= '0;
         dsr_q   <= '0;
      end else if (load) begin
         shreg_q <= dvd_in;
         part_q  <= '0;
         dsr_q   <= dsr_in;
      end else if (step) begin
         shreg_q <= {shreg_q[DATA_W-2:0], fits};
         part_q  <= fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
      end
   end

   assign quo_mag = shreg_q;
   assign rem_mag = part_q;

endmodule

// File: rtl/divrem_post.sv
`timescale 1ns/1ps
// Applies result signs and extends narrow results to the full width
module divrem_post
   import divrem_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  dr_size_e          size,
   input  logic              is_signed,
   input  logic              neg_quo,
   input  logic              neg_rem,
   input  logic [DATA_W-1:0] quo_mag,
   input  logic [DATA_W-1:0] rem_mag,
   output logic [DATA_W-1:0] quo,
   output logic [DATA_W-1:0] rem
);

   logic [DATA_W-1:0] c_q [NUM_SIZES];
   logic [DATA_W-1:0] c_r [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_w
      localparam int W = DATA_W >> (NUM_SIZES - 1 - g);
      localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - W);

      logic [DATA_W-1:0] q_m, r_m;

      assign q_m = (neg_quo ? -quo_mag : quo_mag) & MASK;
      assign r_m = (neg_rem ? -rem_mag : rem_mag) & MASK;
      assign c_q[g] = (is_signed & q_m[W-1]) ? (q_m | ~MASK) : q_m;
      assign c_r[g] = (is_signed & r_m[W-1]) ? (r_m | ~MASK) : r_m;
   end

   always_comb begin
      quo = c_q[size];
      rem = c_r[size];
   end

endmodule

// File: rtl/divrem_unit.sv
`timescale 1ns/1ps
module divrem_unit
   import divrem_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_size,
   input  logic              op_signed,
   input  logic [DATA_W-1:0] dividend,
   input  logic [DATA_W-1:0] divisor,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] quotient,
   output logic [DATA_W-1:0] remainder
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("divrem_unit: DATA_W must be a power of two of at least 8");
   end

   dr_state_e         state_q;
   logic              done_q;
   logic [CNT_W-1:0]  cnt_q;
   dr_size_e          sz_q;
   logic              sgn_q, negq_q, negr_q, div0_q;
   logic [DATA_W-1:0] aext_q;

   dr_size_e          req_size;
   logic [DATA_W-1:0] dvd_aligned, dsr_mag, dvd_ext;
   logic              neg_dvd, neg_dsr, dsr_zero;
   logic [CNT_W-1:0]  nbits;
   logic [DATA_W-1:0] quo_mag, rem_mag, quo_s, rem_s;
   logic              accept, run;

   assign req_size = dr_size_e'(op_size);
   assign run      = (state_q == ST_RUN);
   assign accept   = start & ~run;

   divrem_prep #(.DATA_W(DATA_W)) u_prep (
      .size        (req_size),
      .is_signed   (op_signed),
      .dividend    (dividend),
      .divisor     (divisor),
      .dvd_aligned (dvd_aligned),
      .dsr_mag     (dsr_mag),
      .dvd_ext     (dvd_ext),
      .neg_dvd     (neg_dvd),
      .neg_dsr     (neg_dsr),
      .dsr_zero    (dsr_zero),
      .nbits       (nbits)
   );

   divrem_core #(.DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept & ~dsr_zero),
      .step    (run),
      .dvd_in  (dvd_aligned),
      .dsr_in  (dsr_mag),
      .quo_mag (quo_mag),
      .rem_mag (rem_mag)
   );

   divrem_post #(.DATA_W(DATA_W)) u_post (
      .size      (sz_q),
      .is_signed (sgn_q),
      .neg_quo   (negq_q),
      .neg_rem   (negr_q),
      .quo_mag   (quo_mag),
      .rem_mag   (rem_mag),
      .quo       (quo_s),
      .rem       (rem_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         sz_q    <= SZ_8;
         sgn_q   <= 1'b0;
         negq_q  <= 1'b0;
         negr_q  <= 1'b0;
         div0_q  <= 1'b0;
         aext_q  <= '0;
      end else if (accept) begin
         sz_q   <= req_size;
         sgn_q  <= op_signed;
         negq_q <= neg_dvd ^ neg_dsr;
         negr_q <= neg_dvd;
         div0_q <= dsr_zero;
         aext_q <= dvd_ext;
         cnt_q  <= nbits;
         if (dsr_zero) begin
            done_q <= 1'b1;
         end else begin
            done_q  <= 1'b0;
            state_q <= ST_RUN;
         end
      end else if (run) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy      = run;
   assign done      = done_q;
   assign quotient  = div0_q ? {DATA_W{1'b1}} : quo_s;
   assign remainder = div0_q ? aext_q : rem_s;

endmodule

// File: rtl/divrem_chk.sv
`timescale 1ns/1ps
module divrem_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [DATA_W-1:0] divisor,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] quotient,
   input logic [DATA_W-1:0] remainder
);

   localparam int LEN_W = $clog2(DATA_W + 2);

   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + LEN_W'(1);
      else           run_len <= '0;
   end

   // R6
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R6
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < LEN_W'(DATA_W)));

   // R5
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor == '0) |=> (done && !busy && quotient == {DATA_W{1'b1}}));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

endmodule

bind divrem_unit divrem_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .divisor   (divisor),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder)
);

// File: tb/divrem_unit_bench.sv
`timescale 1ns/1ps
module divrem_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_size = 2'd0;
   logic        op_signed = 1'b0;
   logic [63:0] dividend = '0;
   logic [63:0] divisor = '0;
   logic        busy, done;
   logic [63:0] quotient, remainder;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   divrem_unit #(.DATA_W(64)) u_divrem_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
      .op_signed(op_signed), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
   );

   // {size[2], signed[1], dividend[64], divisor[64], quotient[64], remainder[64]}
   localparam int NV = 14;
   localparam logic [258:0] VEC [NV] = '{
      {2'd3, 1'b0, 64'd100, 64'd7, 64'd14, 64'd2},                                            // R2
      {2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC8, 64'hAB00_0000_0000_0003, 64'h42, 64'h2},            // R9
      {2'd0, 1'b1, 64'h0000_0000_0000_00C8, 64'd5, 64'hFFFF_FFFF_FFFF_FFF5, 64'hFFFF_FFFF_FFFF_FFFF}, // R3
      {2'd1, 1'b1, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF, 64'hFFFF_FFFF_FFFF_8000, 64'h0}, // R4
      {2'd2, 1'b1, 64'd7, 64'h0000_0000_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFD, 64'd1},              // R3
      {2'd2, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h10, 64'h0FFF_FFFF, 64'hF},                       // R2
      {2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 64'hFFFF_FFFF_FFFF_FFF2, 64'hFFFF_FFFF_FFFF_FFFE}, // R3
      {2'd3, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h0}, // R4
      {2'd1, 1'b0, 64'h1234, 64'h1235, 64'h0, 64'h1234},                                       // R2
      {2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}, // R5
      {2'd0, 1'b1, 64'h1111_1111_1111_1180, 64'h0000_0000_0000_FF00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF80}, // R5
      {2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_ABCD, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD}, // R5
      {2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1},             // R2
      {2'd0, 1'b1, 64'h7F, 64'h80, 64'h0, 64'h7F}                                              // R3
   };

   function automatic string tag_of(int idx);
      case (idx)
         1:          return "R9";
         3, 7:       return "R4";
         9, 10, 11:  return "R5";
         2, 4, 6, 13: return "R3";
         default:    return "R2";
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] sz, input logic sg, input logic [63:0] a,
                         input logic [63:0] b, output int bcyc);
      @(negedge clk);
      start = 1'b1; op_size = sz; op_signed = sg; dividend = a; divisor = b;
      @(negedge clk);
      start = 1'b0;
      bcyc = 0;
      for (int i = 0; i < 300; i++) begin
         if (done) break;
         if (busy) bcyc++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      #(5 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      int bc;
      logic [258:0] v;
      logic [63:0] q_keep, r_keep;

      repeat (3) @(negedge clk);
      // R1: reset values, during and just after reset
      chk("R1", {63'd0, busy}, 64'd0);
      chk("R1", {63'd0, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", quotient, 64'd0);
      chk("R1", remainder, 64'd0);
      chk("R1", {62'd0, busy, done}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         run_op(v[258:257], v[256], v[255:192], v[191:128], bc);
         chk(tag_of(i), quotient, v[127:64]);
         chk(tag_of(i), remainder, v[63:0]);
         chk(tag_of(i), {63'd0, done}, 64'd1);
         // R6 / R5: busy lasts N cycles, none for a zero divisor
         chk((i >= 9 && i <= 11) ? "R5" : "R6", 64'(bc),
             (i >= 9 && i <= 11) ? 64'd0 : 64'(8 << v[258:257]));
         @(negedge clk);
         // R6: done is a single-cycle pulse
         chk("R6", {62'd0, busy, done}, 64'd0);
      end

      // R7: start pulsed in the middle of an operation is ignored
      @(negedge clk);
      start = 1'b1; op_size = 2'd3; op_signed = 1'b0; dividend = 64'd100; divisor = 64'd7;
      @(negedge clk);
      start = 1'b0;
      bc = 0;
      for (int i = 0; i < 300; i++) begin
         if (done) break;
         if (busy) bc++;
         if (i == 10) begin
            start = 1'b1; op_size = 2'd0; dividend = 64'd5; divisor = 64'd0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R7", 64'(bc), 64'd64);
      chk("R7", quotient, 64'd14);
      chk("R7", remainder, 64'd2);

      // R8: results held while idle with inputs changing
      q_keep = quotient;
      r_keep = remainder;
      dividend = 64'hDEAD_BEEF_0000_0001; divisor = 64'd3; op_signed = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8", quotient, q_keep);
      chk("R8", remainder, r_keep);
      chk("R8", {62'd0, busy, done}, 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule